// File: doc/BRIEF.md
# Tick-Driven Match Counter

This block is a timekeeping counter that advances once for every cycle in which an external prescaler raises its tick input, provided the block is enabled. It runs in one of two widths chosen at run time. In wide mode it counts over 32 bits, has four compare channels, and can optionally restart from zero after channel 0 matches. In narrow mode it counts over 16 bits, restarts after a programmable period, and uses all six compare channels.

Software reaches the block through a single-cycle register write port and a combinational read port. Overflow and compare matches set sticky flags, and software clears them by writing ones. A mask chooses which of these conditions also drive a one-cycle event pulse toward other logic. The mask can only be changed while the counter is stopped.

Top module: `tick_match_counter`

## Requirements
- R1: After reset, the control register (address 0: bit 0 run, bit 1 wide mode, bit 2 restart-on-match) reads 0x2. Count (address 1), every compare register (address 8+i), the event mask (address 3) and the flags (address 4) all read zero, and the period (address 2) reads 0xFFFF.
- R2: While run is set, each clock with tick high advances the count by one. While run is clear, tick has no effect on the count.
- R3: In wide mode without restart-on-match, a tick at count 0xFFFFFFFF moves the count to 0 and sets the overflow flag (flag bit 0).
- R4: In narrow mode, a tick taken while the low 16 bits of count equal the period moves the count to 0 and sets the overflow flag. Any other tick counts modulo 2^16.
- R5: Channel i sets flag bit 1+i on the tick that makes the count equal to compare register i. Narrow mode compares 16 bits on channels 0 to 5. Wide mode compares 32 bits on channels 0 to 3, and channels 4 and 5 never set a flag.
- R6: In wide mode with restart-on-match set, the tick taken while the count equals compare 0 moves the count to 0 and does not set overflow. In narrow mode restart-on-match has no effect.
- R7: Flags are sticky until cleared. Writing address 4 clears exactly the flag bits written as one and leaves the others.
- R8: In the same clock that a flag sets, output event bit k pulses high for one cycle if event mask bit k (same bit layout as the flags) is set.
- R9: A write to the event mask while run is set is ignored.
- R10: A write to count takes effect at the next clock and wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance request from prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| flags | output | 7 | Sticky flags: bit 0 overflow, bit 1+i channel i |
| evt_out | output | 7 | One-cycle event pulses, same layout as flags |

## Verification
The hardest states to reach are the wrap points, because counting up from zero would take 2^32 ticks. The stimulus therefore loads the count with a value just below the wrap, such as 0xFFFFFFFE or the period, and then ticks a few times. A count load in the same cycle as a tick is driven on purpose to show which one wins. Event pulses are checked in the cycle the flag sets and again in the cycle after it, which shows the pulse lasts one cycle. To change the event mask, the bench first stops the counter. It then writes the mask again while the counter runs, to show that the second write is ignored.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    localparam int unsigned CNT_W        = 32;
    localparam int unsigned HALF_W       = 16;
    localparam int unsigned NUM_CMP      = 6;
    localparam int unsigned NUM_CMP_WIDE = 4;
    localparam int unsigned ADDR_W       = 4;
    localparam int unsigned FLAG_W       = NUM_CMP + 1;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_EVMASK = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'd4;
    localparam int unsigned       ADR_CMP0   = 8;

    typedef struct packed {
        logic                            run;
        logic                            wide;
        logic                            restart;
        logic [CNT_W-1:0]                count;
        logic [HALF_W-1:0]               period;
        logic [FLAG_W-1:0]               evmask;
        logic [FLAG_W-1:0]               flags;
        logic [FLAG_W-1:0]               evt;
        logic [NUM_CMP-1:0][CNT_W-1:0]   cmp;
    } tmc_state_t;
endpackage

// File: rtl/tmc_advance.sv
module tmc_advance
    import tmc_pkg::*;
(
    input  logic              wide,
    input  logic              restart,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cmp0,
    input  logic [HALF_W-1:0] period,
    output logic [CNT_W-1:0]  next_count,
    output logic              wrap
);
    logic [HALF_W-1:0] low_inc;

    always_comb begin
        low_inc    = count[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, 1'b1};
        wrap       = 1'b0;
        next_count = count + {{(CNT_W-1){1'b0}}, 1'b1};
        if (wide) begin
            if (restart && (count == cmp0)) begin
                next_count = '0;
            end else if (count == {CNT_W{1'b1}}) begin
                next_count = '0;
                wrap       = 1'b1;
            end
        end else begin
            if (count[HALF_W-1:0] == period) begin
                next_count = '0;
                wrap       = 1'b1;
            end else begin
                next_count = {{(CNT_W-HALF_W){1'b0}}, low_inc};
            end
        end
    end
endmodule

// File: rtl/tmc_match.sv
module tmc_match
    import tmc_pkg::*;
(
    input  logic                           wide,
    input  logic [CNT_W-1:0]               next_count,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp,
    output logic [NUM_CMP-1:0]             hit
);
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_chan
        if (i < NUM_CMP_WIDE) begin : g_both
            assign hit[i] = wide ? (next_count == cmp[i])
                                 : (next_count[HALF_W-1:0] == cmp[i][HALF_W-1:0]);
        end else begin : g_narrow_only
            assign hit[i] = !wide && (next_count[HALF_W-1:0] == cmp[i][HALF_W-1:0]);
        end
    end
endmodule

// File: rtl/tick_match_counter.sv
module tick_match_counter
    import tmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] evt_out
);
    tmc_state_t q, d;

    logic [CNT_W-1:0]   next_count;
    logic               wrap;
    logic [NUM_CMP-1:0] hit;
    logic [FLAG_W-1:0]  set_mask;
    logic [FLAG_W-1:0]  clr_mask;

    tmc_advance i_advance (
        .wide       (q.wide),
        .restart    (q.restart),
        .count      (q.count),
        .cmp0       (q.cmp[0]),
        .period     (q.period),
        .next_count (next_count),
        .wrap       (wrap)
    );

    tmc_match i_match (
        .wide       (q.wide),
        .next_count (next_count),
        .cmp        (q.cmp),
        .hit        (hit)
    );

    always_comb begin
        d        = q;
        set_mask = '0;
        clr_mask = '0;
        if (q.run && tick) begin
            d.count  = next_count;
            set_mask = {hit, wrap};
        end
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    d.run     = wr_data[0];
                    d.wide    = wr_data[1];
                    d.restart = wr_data[2];
                end
                ADR_COUNT:  d.count  = wr_data;
                ADR_PERIOD: d.period = wr_data[HALF_W-1:0];
                ADR_EVMASK: if (!q.run) d.evmask = wr_data[FLAG_W-1:0];
                ADR_FLAGS:  clr_mask = wr_data[FLAG_W-1:0];
                default: begin
                    for (int i = 0; i < NUM_CMP; i++) begin
                        if (wr_addr == ADDR_W'(ADR_CMP0 + i)) d.cmp[i] = wr_data;
                    end
                end
            endcase
        end
        d.flags = (q.flags & ~clr_mask) | set_mask;
        d.evt   = set_mask & q.evmask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.wide   <= 1'b1;
            q.period <= {HALF_W{1'b1}};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL:   rd_data = {{(CNT_W-3){1'b0}}, q.restart, q.wide, q.run};
            ADR_COUNT:  rd_data = q.count;
            ADR_PERIOD: rd_data = {{(CNT_W-HALF_W){1'b0}}, q.period};
            ADR_EVMASK: rd_data = {{(CNT_W-FLAG_W){1'b0}}, q.evmask};
            ADR_FLAGS:  rd_data = {{(CNT_W-FLAG_W){1'b0}}, q.flags};
            default: begin
                for (int i = 0; i < NUM_CMP; i++) begin
                    if (rd_addr == ADDR_W'(ADR_CMP0 + i)) rd_data = q.cmp[i];
                end
            end
        endcase
    end

    assign flags   = q.flags;
    assign evt_out = q.evt;
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker
    import tmc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              run_q,
    input logic              wide_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [FLAG_W-1:0] evmask_q,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] evt_out
);
    logic [FLAG_W-1:0] clr_req;
    logic              cnt_wr;
    assign clr_req = (wr_en && wr_addr == ADR_FLAGS) ? wr_data[FLAG_W-1:0] : '0;
    assign cnt_wr  = wr_en && (wr_addr == ADR_COUNT);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_wr) |=> $stable(count_q));

    // R5
    narrow_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_q && flags[FLAG_W-1:NUM_CMP_WIDE+1] == '0) |=> (flags[FLAG_W-1:NUM_CMP_WIDE+1] == '0));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(clr_req)) & ~flags) == '0));

    // R8
    evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_out & ~flags) == '0);

    // R8
    evt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_out & ~$past(evmask_q)) == '0));

    // R9
    mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(evmask_q));

    // R10
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_q == $past(wr_data)));
endmodule

bind tick_match_counter tmc_checker i_tmc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .run_q    (q.run),
    .wide_q   (q.wide),
    .count_q  (q.count),
    .evmask_q (q.evmask),
    .flags    (flags),
    .evt_out  (evt_out)
);

// File: tb/test_tick_match_counter.sv
module test_tick_match_counter;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [6:0]  flags;
    logic [6:0]  evt_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tick_match_counter i_tick_match_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .flags(flags), .evt_out(evt_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); chk("R1 ctrl", v, 32'h2);
        rd(4'd1, v); chk("R1 count", v, 32'h0);
        rd(4'd2, v); chk("R1 period", v, 32'hFFFF);
        rd(4'd3, v); chk("R1 evmask", v, 32'h0);
        rd(4'd4, v); chk("R1 flags", v, 32'h0);
        for (int i = 0; i < 6; i++) begin
            rd(4'(8 + i), v); chk("R1 cmp", v, 32'h0);
        end
    endtask

    task automatic t_stopped();
        logic [31:0] v;
        wr(4'd1, 32'd7);
        ticks(5);
        rd(4'd1, v); chk("R2 stopped", v, 32'd7);
        wr(4'd0, 32'h3);
        ticks(5);
        rd(4'd1, v); chk("R2 running", v, 32'd12);
    endtask

    task automatic t_wrap32();
        logic [31:0] v;
        wr(4'd1, 32'hFFFF_FFFE);
        wr(4'd4, 32'h7F);
        ticks(1);
        rd(4'd1, v); chk("R3 at max", v, 32'hFFFF_FFFF);
        ticks(1);
        rd(4'd1, v); chk("R3 wrapped", v, 32'h0);
        chk("R3 R5 flags", {25'd0, flags}, 32'h1F);
    endtask

    task automatic t_period16();
        logic [31:0] v;
        wr(4'd0, 32'h1);
        wr(4'd2, 32'd4);
        wr(4'd1, 32'd0);
        wr(4'd4, 32'h7F);
        ticks(4);
        rd(4'd1, v); chk("R4 at period", v, 32'd4);
        chk("R4 no flag yet", {25'd0, flags}, 32'h0);
        ticks(1);
        rd(4'd1, v); chk("R4 wrapped", v, 32'd0);
        chk("R4 R5 flags", {25'd0, flags}, 32'h7F);
    endtask

    task automatic t_compare();
        logic [31:0] v;
        for (int i = 0; i < 6; i++) wr(4'(8 + i), 32'(i + 1));
        wr(4'd2, 32'd10);
        wr(4'd1, 32'd0);
        wr(4'd4, 32'h7F);
        ticks(6);
        chk("R5 narrow six channels", {25'd0, flags}, 32'h7E);
        wr(4'd0, 32'h3);
        wr(4'd1, 32'd0);
        wr(4'd4, 32'h7F);
        ticks(8);
        chk("R5 wide four channels", {25'd0, flags}, 32'h1E);
        rd(4'd1, v); chk("R5 wide count", v, 32'd8);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(4'd0, 32'h7);
        wr(4'd8, 32'd3);
        wr(4'd1, 32'd0);
        wr(4'd4, 32'h7F);
        ticks(3);
        rd(4'd1, v); chk("R6 reached cmp0", v, 32'd3);
        ticks(1);
        rd(4'd1, v); chk("R6 restarted", v, 32'd0);
        chk("R6 no overflow", {31'd0, flags[0]}, 32'd0);
        wr(4'd0, 32'h5);
        wr(4'd1, 32'd0);
        ticks(4);
        rd(4'd1, v); chk("R6 ignored in narrow", v, 32'd4);
    endtask

    task automatic t_w1c();
        wr(4'd0, 32'h3);
        wr(4'd4, 32'h7F);
        wr(4'd1, 32'hFFFF_FFFF);
        ticks(1);
        wr(4'd1, 32'd1);
        ticks(1);
        chk("R7 two flags", {25'd0, flags}, 32'h05);
        wr(4'd4, 32'h04);
        chk("R7 one cleared", {25'd0, flags}, 32'h01);
        wr(4'd4, 32'h00);
        chk("R7 zero write", {25'd0, flags}, 32'h01);
    endtask

    task automatic t_event();
        logic [31:0] v;
        wr(4'd0, 32'h2);
        wr(4'd3, 32'h03);
        rd(4'd3, v); chk("R8 mask set", v, 32'h03);
        wr(4'd8, 32'd0);
        wr(4'd0, 32'h3);
        wr(4'd1, 32'hFFFF_FFFF);
        ticks(1);
        chk("R8 pulse", {25'd0, evt_out}, 32'h03);
        @(negedge clk);
        chk("R8 one cycle", {25'd0, evt_out}, 32'h0);
        ticks(2);
        chk("R8 unmasked channel", {25'd0, evt_out}, 32'h0);
        wr(4'd3, 32'h7F);
        rd(4'd3, v); chk("R9 mask locked", v, 32'h03);
    endtask

    task automatic t_write_wins();
        logic [31:0] v;
        wr(4'd1, 32'd100);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'd500; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(4'd1, v); chk("R10 write wins", v, 32'd500);
        ticks(1);
        rd(4'd1, v); chk("R10 resumes", v, 32'd501);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stopped();
        t_wrap32();
        t_period16();
        t_compare();
        t_restart();
        t_w1c();
        t_event();
        t_write_wins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule